// File: doc/BRIEF.md
# Serial Voltage-ID Command Receiver

This block is the slave side of a two-wire serial voltage-ID bus. A processor acting as bus master sends short write commands that set the target voltage code of two output rails: a CORE rail and a north-bridge (NB) rail. The block watches the clock and data lines, finds START and STOP conditions, and shifts in an address byte and then a data byte. It pulls the data line low during the acknowledge bit after each byte, but only for a command addressed to it. When the command completes, it loads the addressed rail registers.

The address byte has a fixed prefix and two rail-select bits, so one command can retarget CORE, NB, or both with the same code. The data byte holds a 7-bit VID code and an active-low power-saving permission flag. A rail that the command does not select keeps its settings. This lets one rail be switched off or on while the other keeps running.

The bus lines are asynchronous to the system clock. Each line passes through a synchronizer and an edge detector before the protocol engine sees it. The results are plain registered outputs: a VID code and a power-saving flag per rail, and a one-cycle update strobe per rail that marks when new values take effect. These are configuration outputs with no consumer handshake, so no valid/ready back-pressure applies. A strobe is simply a notification that the registers changed.

Top module: `svid_cmd_rx`

## Requirements
- R1: After reset, both VID outputs are 0, both power-saving flags are 1 (not permitted), both update strobes are low and the data-line pull output is low (line released).
- R2: The address acknowledge is driven only when address bits 6:4 equal 110b and the eighth bit (write bit, the last bit clocked) is 0. Any other address byte gets no acknowledge, and the rest of that transaction is ignored until the next START.
- R3: Address bits 3 and 2 have no effect on whether the address is accepted or on which rails are loaded.
- R4: Address bit 1 set selects the CORE rail for loading from the data byte.
- R5: Address bit 0 set selects the NB rail. With bits 1 and 0 both set, both rails load the same data byte.
- R6: Data byte bits 6:0 become the VID output of each selected rail, and data bit 7 becomes its active-low power-saving flag. Bits are received MSB first, sampled on rising clock-line edges.
- R7: The pull output is asserted from the falling clock edge after the eighth bit of an accepted byte until the next falling clock edge, and it is deasserted at all other times.
- R8: Each loaded rail raises its update strobe for exactly one system cycle, after the falling clock edge that ends the data acknowledge. The new values are present in that same cycle. No strobe appears before that edge.
- R9: A STOP, or a repeated START, that arrives before the data acknowledge completes abandons the transaction without changing any rail. A START always begins a fresh address phase.
- R10: A rail that the completed command does not select keeps its VID, its flag and a low strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as observed (asynchronous) |
| sda_i | input | 1 | Bus data line as observed (asynchronous) |
| sda_pull_o | output | 1 | 1 = drive the data line low (open-drain acknowledge) |
| core_vid_o | output | 7 | CORE rail VID code |
| core_psave_n_o | output | 1 | CORE rail power-saving permission, active low |
| core_update_o | output | 1 | One-cycle strobe when CORE values are loaded |
| nb_vid_o | output | 7 | NB rail VID code |
| nb_psave_n_o | output | 1 | NB rail power-saving permission, active low |
| nb_update_o | output | 1 | One-cycle strobe when NB values are loaded |

## Verification
The hardest case to reach is a transaction that dies partway through the data byte. The bus must then be left so that neither rail changes, and a later command must still be decoded correctly. The stimulus reaches it by cutting random commands short after a random number of data bits, using either a STOP or a repeated START. Each cut is followed by a complete command whose result is compared with a bench model. The random address mix also covers rejected prefixes, read-direction bytes and every combination of the rail-select and don't-care bits.

// File: rtl/svid_rx_pkg.sv
package svid_rx_pkg;
  localparam int VID_W     = 7;
  localparam int BYTE_W    = VID_W + 1;
  localparam int N_SECT    = 2;
  localparam int SECT_CORE = 0;
  localparam int SECT_NB   = 1;
  localparam logic [2:0] ADDR_PREFIX = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK
  } rx_state_e;
endpackage

// File: rtl/svid_line_sync.sv
module svid_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], line_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~pipe_q[STAGES-1] & prev_q;
endmodule

// File: rtl/svid_bit_engine.sv
module svid_bit_engine
  import svid_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  output logic              pull_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [N_SECT-1:0] load_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [N_SECT-1:0] sel_q;
  logic              pull_q;
  logic [N_SECT-1:0] load_q;

  logic start_det, stop_det, addr_hit, shift_en;

  assign start_det = scl_lvl_i & sda_fall_i;
  assign stop_det  = scl_lvl_i & sda_rise_i;
  assign addr_hit  = (shreg_q[BYTE_W-1 -: 3] == ADDR_PREFIX) && !shreg_q[0];
  assign shift_en  = scl_rise_i && (cnt_q < FULL) &&
                     (state_q == ST_ADDR || state_q == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      sel_q   <= '0;
      pull_q  <= 1'b0;
      load_q  <= '0;
    end else begin
      load_q <= '0;
      if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else if (shift_en) begin
        shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
        cnt_q   <= cnt_q + 1'b1;
      end else if (scl_fall_i) begin
        unique case (state_q)
          ST_ADDR: if (cnt_q == FULL) begin
            if (addr_hit) begin
              sel_q[SECT_CORE] <= shreg_q[2];
              sel_q[SECT_NB]   <= shreg_q[1];
              pull_q  <= 1'b1;
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_ADDR_ACK: begin
            pull_q  <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
          ST_DATA: if (cnt_q == FULL) begin
            pull_q  <= 1'b1;
            state_q <= ST_DATA_ACK;
          end
          ST_DATA_ACK: begin
            pull_q  <= 1'b0;
            load_q  <= sel_q;
            state_q <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign pull_o = pull_q;
  assign byte_o = shreg_q;
  assign load_o = load_q;

  p_start_fresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_ADDR && cnt_q == '0 && !pull_q));
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && load_q == '0));
  p_pull_in_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> (state_q == ST_ADDR_ACK || state_q == ST_DATA_ACK));
  p_ack_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_ACK) |-> (shreg_q[BYTE_W-1 -: 3] == ADDR_PREFIX && !shreg_q[0]));
  p_load_after_dack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q != '0) |-> ($past(state_q) == ST_DATA_ACK && state_q == ST_IDLE));
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
endmodule

// File: rtl/svid_rail_reg.sv
module svid_rail_reg #(
  parameter int VW = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [VW:0] byte_i,
  output logic [VW-1:0] vid_o,
  output logic        psave_n_o,
  output logic        upd_o
);
  logic [VW-1:0] vid_q;
  logic          psn_q;
  logic          upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q <= '0;
      psn_q <= 1'b1;
      upd_q <= 1'b0;
    end else begin
      upd_q <= load_i;
      if (load_i) begin
        vid_q <= byte_i[VW-1:0];
        psn_q <= byte_i[VW];
      end
    end
  end

  assign vid_o     = vid_q;
  assign psave_n_o = psn_q;
  assign upd_o     = upd_q;

  p_upd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(vid_q) && $stable(psn_q) && !upd_q));
endmodule

// File: rtl/svid_cmd_rx.sv
module svid_cmd_rx
  import svid_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  output logic [VID_W-1:0] core_vid_o,
  output logic             core_psave_n_o,
  output logic             core_update_o,
  output logic [VID_W-1:0] nb_vid_o,
  output logic             nb_psave_n_o,
  output logic             nb_update_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic [BYTE_W-1:0] rx_byte;
  logic [N_SECT-1:0] load;
  logic [VID_W-1:0]  vid_arr [N_SECT];
  logic [N_SECT-1:0] psn_arr;
  logic [N_SECT-1:0] upd_arr;

  svid_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  svid_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  svid_bit_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .pull_o(sda_pull_o), .byte_o(rx_byte), .load_o(load));

  for (genvar s = 0; s < N_SECT; s++) begin : g_rail
    svid_rail_reg #(.VW(VID_W)) u_rail (
      .clk(clk), .rst_n(rst_n), .load_i(load[s]), .byte_i(rx_byte),
      .vid_o(vid_arr[s]), .psave_n_o(psn_arr[s]), .upd_o(upd_arr[s]));
  end

  assign core_vid_o     = vid_arr[SECT_CORE];
  assign core_psave_n_o = psn_arr[SECT_CORE];
  assign core_update_o  = upd_arr[SECT_CORE];
  assign nb_vid_o       = vid_arr[SECT_NB];
  assign nb_psave_n_o   = psn_arr[SECT_NB];
  assign nb_update_o    = upd_arr[SECT_NB];

  p_no_pull_with_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_update_o || nb_update_o) |-> !sda_pull_o);
  p_same_data_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_update_o && nb_update_o) |-> (core_vid_o == nb_vid_o && core_psave_n_o == nb_psave_n_o));
endmodule

// File: tb/svid_cmd_rx_test.sv
`timescale 1ns/1ps
module svid_cmd_rx_test;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [6:0] core_vid, nb_vid;
  logic core_psn, nb_psn, core_upd, nb_upd;
  wire  sda_line = sda_m & ~sda_pull;

  int checks = 0;
  int errors = 0;
  int core_pulses = 0, nb_pulses = 0;
  int core_run = 0, nb_run = 0, max_run = 0;
  logic [6:0] e_core_vid = 7'd0, e_nb_vid = 7'd0;
  logic e_core_psn = 1'b1, e_nb_psn = 1'b1;
  int e_core_pulses = 0, e_nb_pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  svid_cmd_rx uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull),
    .core_vid_o(core_vid), .core_psave_n_o(core_psn), .core_update_o(core_upd),
    .nb_vid_o(nb_vid), .nb_psave_n_o(nb_psn), .nb_update_o(nb_upd));

  always @(posedge clk) begin
    if (core_upd) begin core_pulses++; core_run++; end else core_run = 0;
    if (nb_upd) begin nb_pulses++; nb_run++; end else nb_run = 0;
    if (core_run > max_run) max_run = core_run;
    if (nb_run > max_run) max_run = nb_run;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit addr_ok(input logic [6:0] a, input logic wr);
    return (a[6:4] == 3'b110) && (wr == 1'b0);
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    scl_m = 1'b0; wait_clk(2);
  endtask

  // master releases data; returns whether slave pulled during clock high
  task automatic ack_bit(input bit is_data, output bit acked);
    int cp, np;
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q/2);
    acked = (sda_line == 1'b0);
    cp = core_pulses; np = nb_pulses;
    wait_clk(Q/2);
    if (is_data) begin
      check("R8 no core strobe before ack ends", core_pulses, cp);
      check("R8 no nb strobe before ack ends", nb_pulses, np);
    end
    scl_m = 1'b0; wait_clk(Q/2);
    check("R7 pull released after ack clock", sda_pull, 0);
  endtask

  task automatic check_rails(input string tag);
    check({tag, " R4 core vid"}, core_vid, e_core_vid);
    check({tag, " R6 core flag"}, core_psn, e_core_psn);
    check({tag, " R5 nb vid"}, nb_vid, e_nb_vid);
    check({tag, " R6 nb flag"}, nb_psn, e_nb_psn);
    check({tag, " R10 core strobes"}, core_pulses, e_core_pulses);
    check({tag, " R10 nb strobes"}, nb_pulses, e_nb_pulses);
  endtask

  // abort_mode: 0 none, 1 STOP after abort_bits data bits, 2 repeated START
  task automatic run_xact(input logic [6:0] a, input logic wr, input logic [7:0] d,
                          input int abort_mode, input int abort_bits);
    bit acked;
    bit exp_ack = addr_ok(a, wr);
    bus_start();
    for (int i = 6; i >= 0; i--) send_bit(a[i]);
    send_bit(wr);
    check("R7 no pull before address ack clock", sda_pull, 0);
    ack_bit(1'b0, acked);
    check("R2 address ack", acked, exp_ack);
    if (!exp_ack) begin
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      sda_m = 1'b1; wait_clk(Q);
      check("R2 ignored byte draws no pull", sda_pull, 0);
      scl_m = 1'b1; wait_clk(Q); scl_m = 1'b0; wait_clk(2);
      bus_stop();
      check_rails("rejected");
      return;
    end
    for (int i = 7; i >= 0; i--) begin
      if (abort_mode != 0 && (7 - i) == abort_bits) begin
        if (abort_mode == 1) bus_stop(); else bus_start();
        check_rails("R9 aborted");
        if (abort_mode == 2) begin
          scl_m = 1'b1; wait_clk(Q); sda_m = 1'b1; wait_clk(Q);
        end
        return;
      end
      send_bit(d[i]);
    end
    ack_bit(1'b1, acked);
    check("R7 data ack", acked, 1);
    if (a[1]) begin e_core_vid = d[6:0]; e_core_psn = d[7]; e_core_pulses++; end
    if (a[0]) begin e_nb_vid = d[6:0]; e_nb_psn = d[7]; e_nb_pulses++; end
    bus_stop();
    check_rails("done");
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    wait_clk(5);
    check("R1 reset core vid", core_vid, 0);
    check("R1 reset core flag", core_psn, 1);
    check("R1 reset nb vid", nb_vid, 0);
    check("R1 reset nb flag", nb_psn, 1);
    check("R1 reset pull", sda_pull, 0);
    rst_n = 1'b1;
    wait_clk(5);
    check("R1 no strobes after reset", core_pulses + nb_pulses, 0);

    run_xact(7'b1100010, 1'b0, 8'h35, 0, 0);   // R4 core only, flag 0
    run_xact(7'b1100001, 1'b0, 8'hA2, 0, 0);   // R5 nb only
    run_xact(7'b1100011, 1'b0, 8'hFF, 0, 0);   // R5 both
    run_xact(7'b1101110, 1'b0, 8'h00, 0, 0);   // R3 don't-care bits set
    run_xact(7'b1100000, 1'b0, 8'h12, 0, 0);   // acked, nothing selected
    run_xact(7'b0100011, 1'b0, 8'h44, 0, 0);   // R2 bad prefix
    run_xact(7'b1100011, 1'b1, 8'h44, 0, 0);   // R2 read bit
    run_xact(7'b1100011, 1'b0, 8'h5A, 1, 7);   // R9 stop late
    run_xact(7'b1100011, 1'b0, 8'h5A, 2, 3);   // R9 repeated start
    run_xact(7'b1100010, 1'b0, 8'h7F, 0, 0);   // R9 recovery

    for (int n = 0; n < 50; n++) begin
      logic [6:0] a = 7'($urandom);
      logic [7:0] d = 8'($urandom);
      logic wr = ($urandom % 8) == 0;
      int r = $urandom % 6;
      if (($urandom % 4) != 0) a[6:4] = 3'b110;
      run_xact(a, wr, d, (r < 2) ? r + 1 : 0, $urandom % 8);
    end

    check("R8 strobe width", max_run, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule